// File: doc/BRIEF.md
# Self-Timed Ripple FIFO Register

This block is an elastic first-in-first-out store of 16 words of 4 bits. It is a chain of word stages. Each stage holds one data word and one occupancy marker. A word written at the input end moves toward the output end one stage per clock, whenever the stage ahead of it is vacant. Vacant slots therefore travel back toward the input. No read or write pointers exist. The input-side readiness flag is taken directly from the first stage's marker, and the output-side flag from the last stage's marker.

The block is synchronous. The write strobe and read strobe are levels sampled on the system clock. A write happens on a sampled rising edge of the write strobe. A read happens on a sampled falling edge of the read strobe, qualified by an output-disable control. An asynchronous, active-high master clear empties the chain without touching the stored data bits. While output-disable is high, the output bus is forced to zero and a separate valid flag is low.

Top module: `ripple_fifo`

## Requirements
- R1: With WIDTH=4 and DEPTH=16 the chain holds exactly 16 words: after 16 writes `in_ready` stays low, and a 17th write made while full is dropped and never reaches the output.
- R2: A word written into an empty chain appears at the output after DEPTH clock edges, counting the edge that captured it: `out_ready` is still low after 15 edges and high after 16.
- R3: `in_ready` is high exactly when the first stage is vacant. After a write into an empty chain it is low for one clock, then high again once the word has moved to the second stage.
- R4: A write occurs on a sampled low-to-high change of `shift_in` while `in_ready` is high. Holding `shift_in` high for several clocks stores only one word.
- R5: A read occurs on a sampled high-to-low change of `shift_out` while `out_ready` is high. `out_ready` is low after the edge that performs the read. If another word sits in the next stage, `out_ready` is high again one clock later.
- R6: While the chain is empty, a `shift_out` pulse is ignored and is not remembered. A word written later stays at the output.
- R7: While `out_disable` is high, no read takes place. If `out_disable` falls while `shift_out` is low, the output word is removed at that edge.
- R8: While `out_disable` is high, `dout` is all zeros and `dout_valid` is low. Otherwise `dout` equals the last stage's word and `dout_valid` is high.
- R9: A high `mreset` clears every marker, so `in_ready` goes high and `out_ready` goes low. The stored data bits are kept, so `dout` still shows the word that was in the last stage.
- R10: Words leave in the order they were written, for every fill level from 1 to DEPTH.
- R11: After one read from a full chain, the vacancy travels back one stage per clock. `in_ready` is still low 14 clocks after the read edge and high 15 clocks after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Asynchronous active-high master clear of all markers |
| shift_in | input | 1 | Write strobe; rising edge writes |
| din | input | WIDTH | Word to be written |
| in_ready | output | 1 | First stage vacant; a write can be accepted |
| shift_out | input | 1 | Read strobe; falling edge reads |
| out_disable | input | 1 | Blocks reads and forces the output bus to zero |
| dout | output | WIDTH | Word held in the last stage, or zero when disabled |
| dout_valid | output | 1 | High when `dout` is driven from the last stage |
| out_ready | output | 1 | Last stage occupied; a word is available |

## Verification
The checker checks these properties on every clock:
- `in_ready` falls after a write and cannot fall without one.
- `out_ready` falls after a read.
- The output word stays put while no read occurs and `out_ready` is high.
- A disabled output keeps its word.
- The bus is masked while `out_disable` is high.
- Both flags are correct on leaving master clear.

Only the bench scenarios can show the following:
- the exact fall-through and back-propagation latencies
- that a write made while full is dropped, and that a read made while empty is not remembered
- that data survives master clear
- that word order is kept at every fill level

// File: rtl/fifo_ripple_pkg.sv
package fifo_ripple_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   localparam int DEF_WIDTH = 4;
   localparam int DEF_DEPTH = 16;

endpackage

// File: rtl/ripple_edge_det.sv
// Sampled edge detector: compares the live level with the value held at the previous clock.
module ripple_edge_det
   import fifo_ripple_pkg::*;
#(
   parameter edge_kind_e KIND = EDGE_RISE
) (
   input  logic clk,
   input  logic mreset,
   input  logic level,
   output logic pulse
);

   // The idle value after clear suppresses a spurious edge when the level is held through reset.
   localparam logic IDLE_LEVEL = (KIND == EDGE_RISE);

   logic prev;

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset) prev <= IDLE_LEVEL;
      else        prev <= level;
   end

   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign pulse = level & ~prev;
      end else begin : g_fall
         assign pulse = ~level & prev;
      end
   endgenerate

endmodule

// File: rtl/ripple_stage.sv
// One word slot: occupancy marker plus data word (the data word has no reset).
module ripple_stage #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             take,   // upstream offers a word
   input  logic             drain,  // this word leaves this clock
   input  logic [WIDTH-1:0] feed,
   output logic             occ,
   output logic [WIDTH-1:0] data_q
);

   always_ff @(posedge clk or posedge mreset) begin
      if (mreset)   occ <= 1'b0;
      else if (occ) occ <= ~drain;
      else          occ <= take;
   end

   always_ff @(posedge clk) begin
      if (!occ && take) data_q <= feed;
   end

endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
   import fifo_ripple_pkg::*;
#(
   parameter int WIDTH = DEF_WIDTH,
   parameter int DEPTH = DEF_DEPTH
) (
   input  logic             clk,
   input  logic             mreset,
   input  logic             shift_in,
   input  logic [WIDTH-1:0] din,
   output logic             in_ready,
   input  logic             shift_out,
   input  logic             out_disable,
   output logic [WIDTH-1:0] dout,
   output logic             dout_valid,
   output logic             out_ready
);

   localparam int LAST = DEPTH - 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ripple_fifo: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("ripple_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] occ;
   logic [DEPTH-1:0] take;
   logic [DEPTH-1:0] drain;
   logic [WIDTH-1:0] word [DEPTH];
   logic [WIDTH-1:0] feed [DEPTH];

   logic si_edge, so_edge, out_gate;
   logic load_fire, unload_fire;

   // Read gate: its falling edge is a read, so a disable held high masks the strobe,
   // and a disable release with the strobe low completes a pending read.
   assign out_gate = shift_out | out_disable;

   ripple_edge_det #(.KIND(EDGE_RISE)) u_in_edge (
      .clk   (clk),
      .mreset(mreset),
      .level (shift_in),
      .pulse (si_edge)
   );

   ripple_edge_det #(.KIND(EDGE_FALL)) u_out_edge (
      .clk   (clk),
      .mreset(mreset),
      .level (out_gate),
      .pulse (so_edge)
   );

   assign load_fire   = si_edge & ~occ[0];
   assign unload_fire = so_edge & occ[LAST];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_chain
         if (i == 0) begin : g_head
            assign take[i] = load_fire;
            assign feed[i] = din;
         end else begin : g_body_in
            assign take[i] = occ[i-1];
            assign feed[i] = word[i-1];
         end

         if (i == LAST) begin : g_tail
            assign drain[i] = unload_fire;
         end else begin : g_body_out
            assign drain[i] = ~occ[i+1];
         end

         ripple_stage #(.WIDTH(WIDTH)) u_stage (
            .clk   (clk),
            .mreset(mreset),
            .take  (take[i]),
            .drain (drain[i]),
            .feed  (feed[i]),
            .occ   (occ[i]),
            .data_q(word[i])
         );
      end
   endgenerate

   assign in_ready   = ~occ[0];
   assign out_ready  = occ[LAST];
   assign dout_valid = ~out_disable;
   assign dout       = out_disable ? '0 : word[LAST];

endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
   parameter int WIDTH = 4,
   parameter int DEPTH = 16
) (
   input logic             clk,
   input logic             mreset,
   input logic             in_ready,
   input logic             out_ready,
   input logic             out_disable,
   input logic [WIDTH-1:0] dout,
   input logic             dout_valid,
   input logic             load_fire,
   input logic             unload_fire,
   input logic [WIDTH-1:0] last_word
);

   p_load_blocks_input_r3: assert property (@(posedge clk) disable iff (mreset)
      load_fire |=> !in_ready);

   p_ready_needs_write_r4: assert property (@(posedge clk) disable iff (mreset)
      (in_ready && !load_fire) |=> in_ready);

   p_read_drops_flag_r5: assert property (@(posedge clk) disable iff (mreset)
      unload_fire |=> !out_ready);

   p_output_held_r6: assert property (@(posedge clk) disable iff (mreset)
      (out_ready && !unload_fire) |=> (out_ready && $stable(last_word)));

   p_disable_blocks_r7: assert property (@(posedge clk) disable iff (mreset)
      (out_disable && out_ready) |=> out_ready);

   p_disable_masks_r8: assert property (@(posedge clk) disable iff (mreset)
      out_disable |-> (dout == '0 && !dout_valid));

   p_clear_flags_r9: assert property (@(posedge clk) disable iff (mreset)
      $fell(mreset) |-> (in_ready && !out_ready));

endmodule

bind ripple_fifo ripple_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .mreset     (mreset),
   .in_ready   (in_ready),
   .out_ready  (out_ready),
   .out_disable(out_disable),
   .dout       (dout),
   .dout_valid (dout_valid),
   .load_fire  (load_fire),
   .unload_fire(unload_fire),
   .last_word  (word[DEPTH-1])
);

// File: tb/ripple_fifo_tb.sv
`timescale 1ns/1ps
module ripple_fifo_tb;

   localparam int W = 4;
   localparam int D = 16;

   logic         clk = 1'b0;
   logic         mreset = 1'b1;
   logic         shift_in = 1'b0;
   logic [W-1:0] din = '0;
   logic         in_ready;
   logic         shift_out = 1'b0;
   logic         out_disable = 1'b0;
   logic [W-1:0] dout;
   logic         dout_valid;
   logic         out_ready;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   ripple_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
      .clk        (clk),
      .mreset     (mreset),
      .shift_in   (shift_in),
      .din        (din),
      .in_ready   (in_ready),
      .shift_out  (shift_out),
      .out_disable(out_disable),
      .dout       (dout),
      .dout_valid (dout_valid),
      .out_ready  (out_ready)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push(logic [W-1:0] v);
      din = v;
      shift_in = 1'b1;
      tick();
      shift_in = 1'b0;
      tick();
   endtask

   task automatic pop(logic [W-1:0] exp, string req);
      for (int t = 0; t < 64 && !out_ready; t++) tick();
      chk({req, " ready"}, int'(out_ready), 1);
      chk({req, " data"}, int'(dout), int'(exp));
      shift_out = 1'b1;
      tick();
      shift_out = 1'b0;
      tick();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) tick();
      mreset = 1'b0;
      tick();

      // R9 R3: flags after clear
      chk("R9 in_ready after clear", int'(in_ready), 1);
      chk("R9 out_ready after clear", int'(out_ready), 0);
      chk("R8 valid when enabled", int'(dout_valid), 1);

      // R3 R2: single word latency
      din = 4'hA;
      shift_in = 1'b1;
      tick();
      chk("R3 in_ready low after write", int'(in_ready), 0);
      shift_in = 1'b0;
      tick();
      chk("R3 in_ready back high", int'(in_ready), 1);
      repeat (13) tick();
      chk("R2 not yet at output", int'(out_ready), 0);
      tick();
      chk("R2 at output after DEPTH edges", int'(out_ready), 1);
      chk("R8 dout shows last word", int'(dout), 10);

      // R8 R7: disable masks bus and blocks the read
      out_disable = 1'b1;
      #1;
      chk("R8 dout zero when disabled", int'(dout), 0);
      chk("R8 valid low when disabled", int'(dout_valid), 0);
      shift_out = 1'b1;
      tick();
      shift_out = 1'b0;
      tick();
      tick();
      chk("R7 read blocked while disabled", int'(out_ready), 1);
      out_disable = 1'b0;
      tick();
      chk("R7 release with strobe low reads", int'(out_ready), 0);

      // R6: read on empty is not remembered
      shift_out = 1'b1;
      tick();
      shift_out = 1'b0;
      tick();
      push(4'h5);
      repeat (D) tick();
      chk("R6 word survives earlier empty read", int'(out_ready), 1);
      pop(4'h5, "R6");
      chk("R5 out_ready low after read", int'(out_ready), 0);

      // R4: held strobe writes once
      din = 4'h7;
      shift_in = 1'b1;
      repeat (6) tick();
      shift_in = 1'b0;
      tick();
      pop(4'h7, "R4");
      repeat (D + 4) tick();
      chk("R4 only one word from held strobe", int'(out_ready), 0);

      // R1: fill to capacity, extra write dropped
      for (int k = 0; k < D; k++) push(W'((k * 5 + 3) % 16));
      repeat (D + 4) tick();
      chk("R1 in_ready low when full", int'(in_ready), 0);
      push(4'hF);
      pop(W'(3), "R10 first of full");
      tick();
      chk("R5 next word one clock later", int'(out_ready), 1);
      repeat (13) tick();
      chk("R11 vacancy not yet at input", int'(in_ready), 0);
      tick();
      chk("R11 vacancy reached input", int'(in_ready), 1);
      for (int k = 1; k < D; k++) pop(W'((k * 5 + 3) % 16), "R10 full drain");
      repeat (D + 4) tick();
      chk("R1 write while full was dropped", int'(out_ready), 0);

      // R9: clear keeps data bits
      push(4'h9);
      push(4'hB);
      repeat (D + 4) tick();
      mreset = 1'b1;
      tick();
      mreset = 1'b0;
      tick();
      chk("R9 in_ready after mid clear", int'(in_ready), 1);
      chk("R9 out_ready after mid clear", int'(out_ready), 0);
      chk("R9 data kept", int'(dout), 9);
      push(4'h2);
      pop(4'h2, "R9 new word supersedes");

      // R10: order at every fill level
      for (int n = 1; n <= D; n++) begin
         for (int k = 0; k < n; k++) push(W'((n + 3 * k) % 16));
         for (int k = 0; k < n; k++) pop(W'((n + 3 * k) % 16), "R10 sweep");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule